// File: doc/BRIEF.md
# Serial Clock Phase Timer

This block produces the initiator's serial clock level for a two-wire serial bus. It derives the clock from the peripheral clock, timing the low phase and the high phase with two separate 8-bit counts. The counts come from a 16-bit divisor word: the high-phase count is in bits [15:8] and the low-phase count is in bits [7:0]. The high phase lasts its count plus two peripheral cycles. The low phase lasts its count plus one peripheral cycle. With both counts at 0x1F, the high phase is 33 cycles and the low phase is 32 cycles. At a 26 MHz peripheral clock, a low count of 0x21 and a high count of 0x1D give about 1300 ns low and 1200 ns high, which is roughly a 400 kHz bus.

The block also puts out two one-cycle strobes, one for the rising edge and one for the falling edge of the clock. A separate bit-level sequencer uses them to place data changes and samples. While the enable is low, the clock is released high. Each enable starts a complete low phase. The block reads a duration from the divisor word at the start of the phase that uses it. A phase already in progress never changes length.

Top module: `scl_tmr`

## Requirements
- R1: While reset is applied (synchronous, active high), and after it is released with the enable low, `scl_o` is 1 and both strobes are 0.
- R2: The high phase lasts HIGH+2 peripheral cycles, where HIGH is bits [15:8] of `div_i`.
- R3: The low phase lasts LOW+1 peripheral cycles, where LOW is bits [7:0] of `div_i`.
- R4: A divisor word of 0x1F1F gives 32 low cycles and 33 high cycles. 0x1D21 gives 34 low cycles and 31 high cycles.
- R5: A phase's duration is taken from `div_i` in the cycle that phase begins. Changing `div_i` during a phase does not change that phase's length.
- R6: If `en_i` is sampled low, `scl_o` is 1 from the next cycle on and no falling strobe occurs. If `en_i` is then sampled high, `scl_o` goes low in the next cycle for a full LOW+1 phase.
- R7: `fall_o` is 1 in exactly the first cycle of each low phase. `rise_o` is 1 in exactly the first cycle in which `scl_o` is 1 after a low phase, and this includes a low phase cut short by disabling.
- R8: The two strobes are never 1 together. `scl_o` changes value only in a cycle in which one of the strobes is 1.
- R9: A LOW of 0 gives a 1-cycle low phase. A HIGH of 0 gives a 2-cycle high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Runs the clock when 1; releases it high when 0 |
| div_i | input | 16 | Divisor word: HIGH count in [15:8], LOW count in [7:0] |
| scl_o | output | 1 | Serial clock drive level |
| rise_o | output | 1 | One-cycle strobe in the first high cycle after a low phase |
| fall_o | output | 1 | One-cycle strobe in the first cycle of a low phase |

## Verification
Some rules hold cycle by cycle, and the assertions check them at every edge. The strobes are exclusive, and each strobe lines up with an actual change of `scl_o`. `scl_o` never moves without a strobe. A disable always releases the clock high, and the down-counter never wraps once it has expired. Phase lengths for given divisor values, the exact moment `div_i` is read, and the full low phase after re-enabling can only be shown by scenarios. The bench covers these with a behavioural model compared every cycle and with measured low-run and high-run lengths, including zero counts and a divisor change partway through a phase.

// File: rtl/scl_tmr_pkg.sv
package scl_tmr_pkg;

    // Clock phase of the timer; IDLE holds the line released.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Extra cycles added on top of the programmed counts.
    localparam int unsigned HIGH_EXTRA = 2;
    localparam int unsigned LOW_EXTRA  = 1;

    // Down-counter start value for a phase: total length minus one.
    localparam int unsigned HIGH_BIAS = HIGH_EXTRA - 1;
    localparam int unsigned LOW_BIAS  = LOW_EXTRA - 1;

    // Default divisor counts.
    localparam logic [7:0] HIGH_DEFAULT = 8'h1F;
    localparam logic [7:0] LOW_DEFAULT  = 8'h1F;

    // Edge strobes carried as one bundle.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_stb_t;

endpackage

// File: rtl/scl_tmr_cnt.sv
module scl_tmr_cnt #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == '0);

    logic pv_q;
    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b1;
    end

    // R2
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q && expire && !load) |=> expire);

endmodule

// File: rtl/scl_tmr_dur.sv
module scl_tmr_dur
    import scl_tmr_pkg::*;
#(
    parameter int unsigned DUR_W = 8
) (
    input  logic [2*DUR_W-1:0] div_i,
    input  logic               pick_high,
    output logic [DUR_W:0]     load_val
);
    localparam int unsigned CNT_W = DUR_W + 1;

    logic [DUR_W-1:0] high_cnt;
    logic [DUR_W-1:0] low_cnt;

    assign high_cnt = div_i[2*DUR_W-1:DUR_W];
    assign low_cnt  = div_i[DUR_W-1:0];

    always_comb begin
        if (pick_high) begin
            load_val = {1'b0, high_cnt} + CNT_W'(HIGH_BIAS);
        end else begin
            load_val = {1'b0, low_cnt} + CNT_W'(LOW_BIAS);
        end
    end

endmodule

// File: rtl/scl_tmr_seq.sv
module scl_tmr_seq
    import scl_tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_i,
    input  logic      expire,
    output phase_e    phase,
    output logic      start_low,
    output logic      start_high,
    output edge_stb_t stb
);
    phase_e    phase_q;
    phase_e    phase_d;
    edge_stb_t stb_q;
    edge_stb_t stb_d;

    always_comb begin
        phase_d = phase_q;
        if (!en_i) begin
            phase_d = PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE: phase_d = PH_LOW;
                PH_LOW:  if (expire) phase_d = PH_HIGH;
                PH_HIGH: if (expire) phase_d = PH_LOW;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    assign start_low  = (phase_d == PH_LOW)  && (phase_q != PH_LOW);
    assign start_high = (phase_d == PH_HIGH) && (phase_q != PH_HIGH);

    always_comb begin
        stb_d.fall = start_low;
        stb_d.rise = (phase_q == PH_LOW) && (phase_d != PH_LOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            stb_q   <= '0;
        end else begin
            phase_q <= phase_d;
            stb_q   <= stb_d;
        end
    end

    assign phase = phase_q;
    assign stb   = stb_q;

    logic pv_q;
    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b1;
    end

    // R8
    stb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> !(stb_q.rise && stb_q.fall));

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q && en_i && !expire && phase_q != PH_IDLE) |=> $stable(phase_q));

endmodule

// File: rtl/scl_tmr.sv
module scl_tmr
    import scl_tmr_pkg::*;
#(
    parameter int unsigned DUR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic [2*DUR_W-1:0] div_i,
    output logic               scl_o,
    output logic               rise_o,
    output logic               fall_o
);
    localparam int unsigned CNT_W = DUR_W + 1;

    phase_e           phase;
    logic             start_low;
    logic             start_high;
    logic             expire;
    edge_stb_t        stb;
    logic [CNT_W-1:0] load_val;

    scl_tmr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .expire     (expire),
        .phase      (phase),
        .start_low  (start_low),
        .start_high (start_high),
        .stb        (stb)
    );

    scl_tmr_dur #(.DUR_W(DUR_W)) u_dur (
        .div_i     (div_i),
        .pick_high (start_high),
        .load_val  (load_val)
    );

    scl_tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (start_low || start_high),
        .load_val (load_val),
        .expire   (expire)
    );

    assign scl_o  = (phase != PH_LOW);
    assign rise_o = stb.rise;
    assign fall_o = stb.fall;

    logic pv_q;
    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b1;
    end

    // R1
    rst_idle_chk: assert property (@(posedge clk)
        rst |=> (scl_o && !rise_o && !fall_o));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q && !en_i) |=> (scl_o && !fall_o));

    // R7
    fall_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q && fall_o) |-> (!scl_o && $past(scl_o)));

    // R7
    rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q && rise_o) |-> (scl_o && !$past(scl_o)));

    // R8
    move_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (pv_q && !$stable(scl_o)) |-> (rise_o || fall_o));

endmodule

// File: tb/scl_tmr_bench.sv
module scl_tmr_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_i = 1'b0;
    logic [15:0] div_i = 16'h1F1F;
    logic        scl_o, rise_o, fall_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit model_live = 1'b0;

    always #2.5 clk = ~clk;

    scl_tmr u_scl_tmr (
        .clk(clk), .rst(rst), .en_i(en_i), .div_i(div_i),
        .scl_o(scl_o), .rise_o(rise_o), .fall_o(fall_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 low, 2 high; left = cycles left in phase
    int m_ph = 0;
    int m_left = 0;
    bit m_scl = 1'b1, m_rise = 1'b0, m_fall = 1'b0;

    always @(posedge clk) begin
        m_rise = 1'b0;
        m_fall = 1'b0;
        if (rst) begin
            m_ph = 0;
        end else if (!en_i) begin
            if (m_ph == 1) m_rise = 1'b1;
            m_ph = 0;
        end else if (m_ph == 0) begin
            m_ph = 1; m_left = int'(div_i[7:0]) + 1; m_fall = 1'b1;
        end else begin
            m_left--;
            if (m_left == 0) begin
                if (m_ph == 1) begin
                    m_ph = 2; m_left = int'(div_i[15:8]) + 2; m_rise = 1'b1;
                end else begin
                    m_ph = 1; m_left = int'(div_i[7:0]) + 1; m_fall = 1'b1;
                end
            end
        end
        m_scl = (m_ph != 1);
    end

    // Per-cycle comparison against the model (R7 R8 via strobes, R2 R3 via level)
    always @(negedge clk) begin
        if (model_live) begin
            check({scl_o, rise_o, fall_o} == {m_scl, m_rise, m_fall}, "R7_model",
                  int'({scl_o, rise_o, fall_o}), int'({m_scl, m_rise, m_fall}));
        end
    end

    // Measure the next full low run and high run.
    task automatic measure(input int exp_low, input int exp_high,
                           input string req_low, input string req_high);
        int n;
        while (!fall_o) @(negedge clk);
        n = 0;
        while (scl_o == 1'b0) begin n++; @(negedge clk); end
        check(n == exp_low, req_low, n, exp_low);
        check(rise_o == 1'b1, "R7", int'(rise_o), 1);
        n = 0;
        while (scl_o == 1'b1) begin n++; @(negedge clk); end
        check(n == exp_high, req_high, n, exp_high);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(scl_o && !rise_o && !fall_o, "R1", int'({scl_o, rise_o, fall_o}), 4);
        rst = 1'b0;
        model_live = 1'b1;
        repeat (3) @(negedge clk);
        check(scl_o && !rise_o && !fall_o, "R1", int'({scl_o, rise_o, fall_o}), 4);

        // R6 start: low begins the cycle after en is sampled
        en_i = 1'b1;
        @(negedge clk);
        check(!scl_o && fall_o, "R6", int'({scl_o, fall_o}), 1);
        measure(32, 33, "R4", "R4");
        measure(32, 33, "R4", "R4");

        div_i = 16'h1D21;
        @(negedge clk);
        measure(34, 31, "R3", "R2");
        measure(34, 31, "R4", "R4");

        div_i = 16'h0000;
        @(negedge clk);
        measure(1, 2, "R9", "R9");
        measure(1, 2, "R9", "R9");

        div_i = 16'h0505;
        @(negedge clk);
        measure(6, 7, "R3", "R2");
        // R5: change mid-low; current low keeps old length
        while (!fall_o) @(negedge clk);
        n = 0;
        while (scl_o == 1'b0) begin
            n++;
            if (n == 2) div_i = 16'h0A10;
            @(negedge clk);
        end
        check(n == 6, "R5", n, 6);
        n = 0;
        while (scl_o == 1'b1) begin n++; @(negedge clk); end
        check(n == 12, "R5", n, 12);
        measure(17, 12, "R5", "R5");

        // R6: disable during high phase
        while (!(scl_o && !rise_o)) @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check(scl_o && !rise_o && !fall_o, "R6", int'({scl_o, rise_o, fall_o}), 4);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(scl_o == 1'b1, "R6", int'(scl_o), 1);
        end
        en_i = 1'b1;
        @(negedge clk);
        check(!scl_o && fall_o, "R6", int'({scl_o, fall_o}), 1);
        n = 0;
        while (scl_o == 1'b0) begin n++; @(negedge clk); end
        check(n == 17, "R6", n, 17);

        // R7: disable during low phase gives a rise strobe
        while (!fall_o) @(negedge clk);
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        check(scl_o && rise_o, "R7", int'({scl_o, rise_o}), 3);
        @(negedge clk);
        check(!rise_o && !fall_o, "R8", int'({rise_o, fall_o}), 0);
        en_i = 1'b1;
        measure(17, 12, "R3", "R2");

        model_live = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule